// File: doc/BRIEF.md
# Core Exception Entry Sequencer

This block decides when a processor core leaves its instruction stream for an interrupt handler and where it goes. Three request lines reach it: a maskable external request, a non-maskable interrupt and a decrementer timer request. An exception is accepted only in a cycle where the core reports that an instruction has completed. On acceptance the block copies the external-enable bit into a save register and clears it. It copies the address of the following instruction into a second save register. It then issues a one-cycle redirect to a fixed offset from a 32-bit base address.

A return pulse reverses the entry in one cycle. It restores the enable bit from its save register and redirects fetch to the saved address. The enable bit can also be written directly by the core, which is how software first opens the maskable paths. The pipeline, memory and handler code are outside the block. The core drives `insn_done_i`, `next_pc_i` and `rfi_i` and follows `redirect_o`/`redirect_pc_o`.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `ee_o`, `sav_ee_o`, `sav_pc_o` and `redirect_o` are all 0 and no non-maskable request is pending.
- R2: No exception is accepted in a cycle where `insn_done_i` is 0; pending and level requests wait for a completing instruction.
- R3: A rising edge on `nmi_i` is latched and stays pending until accepted, whatever the value of `ee_o`; its target is `base_i + 0x100` with `cause_o` = 1.
- R4: `irq_i` is a level request accepted only while `ee_o` is 1; its target is `base_i + 0x500` with `cause_o` = 2.
- R5: `dec_i` is a level request accepted only while `ee_o` is 1; its target is `base_i + 0x900` with `cause_o` = 3.
- R6: When several requests are eligible in the same cycle, the non-maskable one wins, then `irq_i`, then `dec_i`.
- R7: On acceptance, `sav_ee_o` takes the old `ee_o`, `ee_o` becomes 0 and `sav_pc_o` takes `next_pc_i`, all visible the cycle after.
- R8: A cycle with `rfi_i` high sets `ee_o` to `sav_ee_o`, redirects to `sav_pc_o` with `cause_o` = 0, and leaves the save registers unchanged; exceptions are not accepted in that cycle.
- R9: `ee_wr_i` loads `ee_din_i` into `ee_o` only in a cycle with no acceptance and no return; otherwise the write is dropped.
- R10: `redirect_o` is high for exactly the cycle after an acceptance or return and low after any cycle with neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | 32 | Vector base address |
| next_pc_i | input | 32 | Address after the completing instruction |
| insn_done_i | input | 1 | An instruction completes this cycle |
| irq_i | input | 1 | Maskable external request, level |
| nmi_i | input | 1 | Non-maskable request, edge |
| dec_i | input | 1 | Decrementer request, level |
| rfi_i | input | 1 | Return-from-interrupt pulse |
| ee_wr_i | input | 1 | Direct write strobe for the enable bit |
| ee_din_i | input | 1 | Value for the direct write |
| ee_o | output | 1 | External-enable bit |
| sav_ee_o | output | 1 | Saved enable bit |
| sav_pc_o | output | 32 | Saved return address |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| cause_o | output | 2 | Redirect reason: 0 return, 1 NMI, 2 IRQ, 3 DEC |

## Verification
The assertions check on every cycle that acceptance needs a completing instruction, that a latched NMI is neither dropped nor outranked, that the maskable paths stay closed while the enable bit is clear, and that entry, return and direct writes move the enable bit and save registers as required. They also check that the redirect strobe falls after an idle cycle and that a return targets the saved address. Only the bench scenarios show the absolute vector addresses for each cause and the result of combining lines against both enable values. They also show the deferral of a request that coincides with a return and a write dropped during entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [1:0] {
    CAUSE_RET = 2'd0,
    CAUSE_NMI = 2'd1,
    CAUSE_IRQ = 2'd2,
    CAUSE_DEC = 2'd3
  } cause_e;
endpackage

// File: rtl/exc_nmi_capture.sv
module exc_nmi_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o
);
  logic nmi_q;
  logic rise;

  assign rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      // a fresh edge in the taking cycle stays pending
      pend_o <= (pend_o & ~take_i) | rise;
    end
  end

  assert_nmi_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !take_i) |=> pend_o);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ee_i,
  input  logic   done_i,
  input  logic   rfi_i,
  input  logic   nmi_pend_i,
  input  logic   irq_i,
  input  logic   dec_i,
  output logic   take_o,
  output cause_e cause_o
);
  always_comb begin
    take_o  = 1'b0;
    cause_o = CAUSE_RET;
    if (done_i && !rfi_i) begin
      if (nmi_pend_i) begin
        take_o  = 1'b1;
        cause_o = CAUSE_NMI;
      end else if (ee_i && irq_i) begin
        take_o  = 1'b1;
        cause_o = CAUSE_IRQ;
      end else if (ee_i && dec_i) begin
        take_o  = 1'b1;
        cause_o = CAUSE_DEC;
      end
    end
  end

  assert_done_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> done_i);
  assert_irq_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ee_i && !nmi_pend_i) |-> !take_o);
  assert_dec_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == CAUSE_DEC) |-> (ee_i && !irq_i && !nmi_pend_i));
  assert_nmi_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !rfi_i && nmi_pend_i) |-> (take_o && cause_o == CAUSE_NMI));
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          rfi_i,
  input  logic          ee_wr_i,
  input  logic          ee_din_i,
  input  logic [AW-1:0] next_pc_i,
  output logic          ee_o,
  output logic          sav_ee_o,
  output logic [AW-1:0] sav_pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ee_o     <= 1'b0;
      sav_ee_o <= 1'b0;
      sav_pc_o <= '0;
    end else if (rfi_i) begin
      ee_o <= sav_ee_o;
    end else if (take_i) begin
      sav_ee_o <= ee_o;
      ee_o     <= 1'b0;
      sav_pc_o <= next_pc_i;
    end else if (ee_wr_i) begin
      ee_o <= ee_din_i;
    end
  end

  assert_entry_save_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !rfi_i) |=> (!ee_o && sav_ee_o == $past(ee_o) && sav_pc_o == $past(next_pc_i)));
  assert_return_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfi_i |=> (ee_o == $past(sav_ee_o) && $stable(sav_pc_o) && $stable(sav_ee_o)));
  assert_direct_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_wr_i && !take_i && !rfi_i) |=> ee_o == $past(ee_din_i));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter logic [AW-1:0] OFF_NMI = AW'('h100),
  parameter logic [AW-1:0] OFF_IRQ = AW'('h500),
  parameter logic [AW-1:0] OFF_DEC = AW'('h900)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          insn_done_i,
  input  logic          irq_i,
  input  logic          nmi_i,
  input  logic          dec_i,
  input  logic          rfi_i,
  input  logic          ee_wr_i,
  input  logic          ee_din_i,
  output logic          ee_o,
  output logic          sav_ee_o,
  output logic [AW-1:0] sav_pc_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o,
  output logic [1:0]    cause_o
);
  logic   nmi_pend;
  logic   take;
  cause_e cause;
  logic [AW-1:0] off;

  exc_nmi_capture u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .take_i (take && cause == CAUSE_NMI),
    .pend_o (nmi_pend)
  );

  exc_arbiter u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ee_i       (ee_o),
    .done_i     (insn_done_i),
    .rfi_i      (rfi_i),
    .nmi_pend_i (nmi_pend),
    .irq_i      (irq_i),
    .dec_i      (dec_i),
    .take_o     (take),
    .cause_o    (cause)
  );

  exc_state #(.AW(AW)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (take),
    .rfi_i     (rfi_i),
    .ee_wr_i   (ee_wr_i),
    .ee_din_i  (ee_din_i),
    .next_pc_i (next_pc_i),
    .ee_o      (ee_o),
    .sav_ee_o  (sav_ee_o),
    .sav_pc_o  (sav_pc_o)
  );

  always_comb begin
    unique case (cause)
      CAUSE_NMI: off = OFF_NMI;
      CAUSE_IRQ: off = OFF_IRQ;
      CAUSE_DEC: off = OFF_DEC;
      default:   off = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      cause_o       <= CAUSE_RET;
    end else begin
      redirect_o <= take | rfi_i;
      if (rfi_i) begin
        redirect_pc_o <= sav_pc_o;
        cause_o       <= CAUSE_RET;
      end else if (take) begin
        redirect_pc_o <= base_i + off;
        cause_o       <= cause;
      end
    end
  end

  assert_nmi_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cause == CAUSE_NMI && !rfi_i) |=> (redirect_pc_o == $past(base_i) + OFF_NMI));
  assert_ret_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfi_i |=> (redirect_o && cause_o == CAUSE_RET && redirect_pc_o == $past(sav_pc_o)));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take && !rfi_i) |=> !redirect_o);
endmodule

// File: tb/exc_entry_seq_test.sv
`timescale 1ns/1ps
module exc_entry_seq_test;
  typedef struct packed {
    logic ee, nmi, irq, dec, done, redir;
    logic [1:0] cause;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2}, // R4 irq open
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0}, // R4 irq masked
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3}, // R5 dec open
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0}, // R5 dec masked
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1}, // R3 nmi ignores ee
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1}, // R6 all lines
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2}, // R6 irq over dec
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0}, // R2 no completion
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}, // R2 no completion
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0}, // quiet
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1}  // R6 nmi with ee clear
  };

  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] base_i = BASE, next_pc_i = '0;
  logic insn_done_i = 0, irq_i = 0, nmi_i = 0, dec_i = 0, rfi_i = 0, ee_wr_i = 0, ee_din_i = 0;
  logic ee_o, sav_ee_o, redirect_o;
  logic [31:0] sav_pc_o, redirect_pc_o;
  logic [1:0] cause_o;

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic [31:0] exp_sav_pc = '0;
  logic exp_sav_ee = 1'b0;

  always #2.5 clk_i = ~clk_i;

  exc_entry_seq uut (.*);

  function automatic logic [31:0] target(input logic [1:0] c);
    case (c)
      2'd1: return BASE + 32'h100;
      2'd2: return BASE + 32'h500;
      2'd3: return BASE + 32'h900;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic write_ee(input logic v);
    ee_wr_i = 1; ee_din_i = v;
    tick();
    ee_wr_i = 0;
  endtask

  task automatic pulse_nmi;
    nmi_i = 1;
    tick();
    nmi_i = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12;
    @(negedge clk_i);
    // R1 reset state
    chk(ee_o == 0, "R1 ee", 32'(ee_o), 0);
    chk(sav_ee_o == 0 && sav_pc_o == 0, "R1 save regs", sav_pc_o, 0);
    chk(redirect_o == 0, "R1 redirect", 32'(redirect_o), 0);
    rst_ni = 1;
    tick();
    insn_done_i = 1; tick(); insn_done_i = 0;
    chk(redirect_o == 0, "R1 no pending nmi", 32'(redirect_o), 0);

    // R9 direct writes
    write_ee(1);
    chk(ee_o == 1, "R9 write 1", 32'(ee_o), 1);
    write_ee(0);
    chk(ee_o == 0, "R9 write 0", 32'(ee_o), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      write_ee(v.ee);
      if (v.nmi) pulse_nmi();
      irq_i = v.irq; dec_i = v.dec; insn_done_i = v.done;
      next_pc_i = 32'h0000_4000 + 32'(i) * 4;
      tick();
      irq_i = 0; dec_i = 0; insn_done_i = 0;
      chk(redirect_o == v.redir, $sformatf("R2/R4/R5 vec%0d redirect", i), 32'(redirect_o), 32'(v.redir));
      if (v.redir) begin
        exp_sav_pc = next_pc_i; exp_sav_ee = v.ee;
        chk(cause_o == v.cause, $sformatf("R6 vec%0d cause", i), 32'(cause_o), 32'(v.cause));
        chk(redirect_pc_o == target(v.cause), $sformatf("R3/R4/R5 vec%0d target", i), redirect_pc_o, target(v.cause));
        chk(ee_o == 0, $sformatf("R7 vec%0d ee cleared", i), 32'(ee_o), 0);
        chk(sav_ee_o == exp_sav_ee, $sformatf("R7 vec%0d sav_ee", i), 32'(sav_ee_o), 32'(exp_sav_ee));
      end else begin
        chk(ee_o == v.ee, $sformatf("R2 vec%0d ee kept", i), 32'(ee_o), 32'(v.ee));
      end
      chk(sav_pc_o == exp_sav_pc, $sformatf("R7 vec%0d sav_pc", i), sav_pc_o, exp_sav_pc);
      tick();
      chk(redirect_o == 0, $sformatf("R10 vec%0d pulse", i), 32'(redirect_o), 0);
    end

    // R3 nmi held while no instruction completes
    write_ee(0);
    pulse_nmi();
    tick(); tick(); tick();
    chk(redirect_o == 0, "R3 waits for completion", 32'(redirect_o), 0);
    insn_done_i = 1; next_pc_i = 32'h0000_8000;
    tick();
    insn_done_i = 0;
    chk(redirect_o && cause_o == 2'd1, "R3 held nmi taken", 32'(cause_o), 1);
    tick();

    // R8 return restores and defers a coincident request
    write_ee(1);
    irq_i = 1; insn_done_i = 1; next_pc_i = 32'h0000_9000;
    tick();
    chk(ee_o == 0 && sav_ee_o == 1, "R7 entry before return", 32'(sav_ee_o), 1);
    rfi_i = 1; next_pc_i = 32'h0000_A000;
    tick();
    rfi_i = 0;
    chk(redirect_o && cause_o == 2'd0, "R8 return cause", 32'(cause_o), 0);
    chk(redirect_pc_o == 32'h0000_9000, "R8 return target", redirect_pc_o, 32'h0000_9000);
    chk(ee_o == 1, "R8 ee restored", 32'(ee_o), 1);
    chk(sav_pc_o == 32'h0000_9000, "R8 save kept", sav_pc_o, 32'h0000_9000);
    next_pc_i = 32'h0000_B000;
    tick();
    irq_i = 0; insn_done_i = 0;
    chk(redirect_o && cause_o == 2'd2, "R8 deferred irq taken", 32'(cause_o), 2);
    chk(sav_pc_o == 32'h0000_B000, "R7 deferred save", sav_pc_o, 32'h0000_B000);

    // R9 write dropped during entry
    write_ee(1);
    dec_i = 1; insn_done_i = 1; ee_wr_i = 1; ee_din_i = 1;
    tick();
    dec_i = 0; insn_done_i = 0; ee_wr_i = 0;
    chk(redirect_o && ee_o == 0, "R9 write dropped on entry", 32'(ee_o), 0);
    tick();
    chk(redirect_o == 0, "R10 idle after entry", 32'(redirect_o), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule